// File: doc/BRIEF.md
# Configuration Request TLP Issuer

This block lets host software issue one single-dword PCIe configuration read or write at a time through a small register window. Software fills in three header dwords and, for a write, one data dword. It then sets a launch bit and polls that same bit. While the bit is set, the block offers the assembled header and data on a transmit valid/ready handshake and then waits for the completion. When the completion arrives, or when a cycle limit runs out, the bit clears. The completion status sits beside the bit, and the read payload sits in its own register.

Before anything is sent, the block checks the header's format, type, length and byte-enable fields. A malformed header is refused on the spot and reported with a distinct status code. Lane placement is left to software: it shifts write data left, and it shifts the returned read dword right, by eight times the low two bits of the register offset.

Top module: `cfg_tlp_issuer`

## Requirements
- R1: After reset every register reads zero, the busy bit is 0 and `tx_valid` is 0.
- R2: Byte addresses 0x460, 0x464 and 0x468 hold header dwords 0, 1 and 2. Address 0x470 holds write data, 0x488 is request/status and 0x48C is read data. All four header and data registers read back what was written, and any other address reads zero.
- R3: Writing 1 to bit 0 of 0x488 while idle with a legal header sets bit 0. In the next cycle `tx_valid` rises, with `tx_hdr` = {dw2, dw1, dw0} (dw0 in bits 31:0) and `tx_data` = the write-data register.
- R4: A header is legal when dw0 has length (bits 9:0) = 1, type (bits 28:24) = 4 and fmt (bits 31:29) = 0 for a read or 2 for a write, and dw1 has bits 31:4 zero and bits 3:0 nonzero. A launch with any other header sends nothing, leaves bit 0 clear, sets the status to 3'b100 and loads read data with all ones.
- R5: `tx_hdr` and `tx_data` stay stable, and `tx_valid` stays high, until the handshake completes with `tx_ready`.
- R6: A `cpl_valid` seen after the request was accepted clears bit 0 and copies `cpl_status` into status bits 7:5. A `cpl_valid` seen before acceptance is ignored.
- R7: A read that completes with status 0 loads read data with `cpl_data`. A write completion leaves read data unchanged.
- R8: A read that fails, whether by a nonzero completion status or by timeout, loads read data with all ones.
- R9: While bit 0 is set, a further launch and any write to the header or write-data registers are ignored.
- R10: If no completion is taken within `TIMEOUT_CYCLES` cycles of the launch, bit 0 clears, `tx_valid` drops and the status becomes 3'b001.
- R11: The request/status register reads status in bits 7:5, busy in bit 0 and zero elsewhere. An accepted launch clears the status to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read otherwise |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from address) |
| tx_valid | output | 1 | Request offered downstream |
| tx_ready | input | 1 | Downstream accepts request |
| tx_hdr | output | 96 | Header dwords {dw2, dw1, dw0} |
| tx_data | output | 32 | Payload dword |
| cpl_valid | input | 1 | Completion present |
| cpl_status | input | 3 | Completion status, 0 = success |
| cpl_data | input | 32 | Completion payload |

## Verification
A wrong sequencer state shows at the ports within one cycle. A request stuck in waiting keeps bit 0 high until the timeout, and a sequencer that skips the send phase never raises `tx_valid`. A timer that counts wrongly moves the edge at which bit 0 falls, so the bench checks the busy bit in the cycle just before the limit and in the cycle at it. Header registers written during a request, and read data left stale by a failed read, are found by reading them back right after each scenario.

// File: rtl/cfg_tlp_issuer.sv
module cfg_tlp_issuer #(
  parameter int TIMEOUT_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [95:0] tx_hdr,
  output logic [31:0] tx_data,
  input  logic        cpl_valid,
  input  logic [2:0]  cpl_status,
  input  logic [31:0] cpl_data
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [11:0] A_HDR0 = 12'h460, A_HDR1 = 12'h464, A_HDR2 = 12'h468;
  localparam logic [11:0] A_WDAT = 12'h470, A_REQ = 12'h488, A_RDAT = 12'h48C;
  localparam logic [2:0] ST_TIMEOUT = 3'b001, ST_BADHDR = 3'b100;

  typedef enum logic [1:0] {IDLE, SEND, WAIT} phase_t;

  phase_t        phase;
  logic [31:0]   dw0, dw1, dw2, wdat, rdat;
  logic [2:0]    cpl_st;
  logic [TW-1:0] timer;

  wire busy    = phase != IDLE;
  wire waiting = phase == WAIT;
  wire wr_en   = bus_sel && bus_we;
  wire launch  = wr_en && bus_addr == A_REQ && bus_wdata[0] && !busy;
  wire is_read = dw0[31:29] == 3'd0;

  wire hdr_ok = dw0[9:0] == 10'd1 && dw0[28:24] == 5'd4 &&
                (dw0[31:29] == 3'd0 || dw0[31:29] == 3'd2) &&
                dw1[31:4] == 28'd0 && dw1[3:0] != 4'd0;

  wire cpl_take    = waiting && cpl_valid;
  wire timeout_hit = busy && !cpl_take && timer == TW'(TIMEOUT_CYCLES - 1);

  assign tx_valid = phase == SEND;
  assign tx_hdr   = {dw2, dw1, dw0};
  assign tx_data  = wdat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= IDLE;
      dw0    <= '0;
      dw1    <= '0;
      dw2    <= '0;
      wdat   <= '0;
      rdat   <= '0;
      cpl_st <= '0;
      timer  <= '0;
    end else begin
      if (wr_en && !busy) begin
        if (bus_addr == A_HDR0) dw0  <= bus_wdata;
        if (bus_addr == A_HDR1) dw1  <= bus_wdata;
        if (bus_addr == A_HDR2) dw2  <= bus_wdata;
        if (bus_addr == A_WDAT) wdat <= bus_wdata;
      end

      if (busy) timer <= timer + 1'b1;

      if (launch) begin
        if (hdr_ok) begin
          phase  <= SEND;
          cpl_st <= '0;
          timer  <= '0;
        end else begin
          cpl_st <= ST_BADHDR;
          rdat   <= '1;
        end
      end else if (cpl_take) begin
        phase  <= IDLE;
        cpl_st <= cpl_status;
        if (is_read) rdat <= (cpl_status == 3'd0) ? cpl_data : '1;
      end else if (timeout_hit) begin
        phase  <= IDLE;
        cpl_st <= ST_TIMEOUT;
        if (is_read) rdat <= '1;
      end else if (tx_valid && tx_ready) begin
        phase <= WAIT;
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_HDR0:  bus_rdata = dw0;
      A_HDR1:  bus_rdata = dw1;
      A_HDR2:  bus_rdata = dw2;
      A_WDAT:  bus_rdata = wdat;
      A_REQ:   bus_rdata = {24'd0, cpl_st, 4'd0, busy};
      A_RDAT:  bus_rdata = rdat;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_tlp_issuer_chk.sv
module cfg_tlp_issuer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [95:0] tx_hdr,
  input logic [31:0] tx_data,
  input logic        busy,
  input logic        waiting,
  input logic        timeout_hit,
  input logic        cpl_valid,
  input logic [2:0]  cpl_status,
  input logic [2:0]  cpl_st
);
  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready && !timeout_hit |=> tx_valid && $stable(tx_hdr) && $stable(tx_data));

  assert_valid_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy);

  assert_legal_hdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_hdr[9:0] == 10'd1 && tx_hdr[28:24] == 5'd4 &&
                 (tx_hdr[31:29] == 3'd0 || tx_hdr[31:29] == 3'd2) && tx_hdr[35:32] != 4'd0);

  assert_cpl_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    waiting && cpl_valid |=> !busy && cpl_st == $past(cpl_status));

  assert_timeout_R10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> !busy && !tx_valid && cpl_st == 3'b001);
endmodule

bind cfg_tlp_issuer cfg_tlp_issuer_chk chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_hdr(tx_hdr), .tx_data(tx_data), .busy(busy), .waiting(waiting),
  .timeout_hit(timeout_hit), .cpl_valid(cpl_valid), .cpl_status(cpl_status),
  .cpl_st(cpl_st)
);

// File: tb/cfg_tlp_issuer_test.sv
module cfg_tlp_issuer_test;
  localparam int PERIOD = 10;
  localparam int TMO = 20;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        tx_valid, tx_ready = 0;
  logic [95:0] tx_hdr;
  logic [31:0] tx_data;
  logic        cpl_valid = 0;
  logic [2:0]  cpl_status = '0;
  logic [31:0] cpl_data = '0;

  int tests = 0, fails = 0;
  bit done = 0;

  cfg_tlp_issuer #(.TIMEOUT_CYCLES(TMO)) uut (.*);

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_dw0(logic [2:0] fmt);
    return {fmt, 5'd4, 14'd0, 10'd1};
  endfunction
  function automatic logic [31:0] mk_be(int where, int size);
    return ((32'd1 << size) - 1) << (where & 3);
  endfunction
  function automatic logic [31:0] mk_dw2(logic [7:0] b, logic [4:0] dv, logic [2:0] fn, logic [11:0] where);
    return {b, dv, fn, 4'd0, where[11:2], 2'd0};
  endfunction

  task automatic setup(logic [31:0] d0, d1, d2, wd);
    wr(12'h460, d0); wr(12'h464, d1); wr(12'h468, d2); wr(12'h470, wd);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 tx_valid", tx_valid, 0);
    foreach (uut.dw0[i]) ;
    for (int i = 0; i < 6; i++) begin
      logic [11:0] a;
      a = (i < 4) ? 12'h460 + 12'(i*4) : (i == 4 ? 12'h488 : 12'h48C);
      if (i == 3) a = 12'h470;
      rd(a, v); chk("R1 reg zero", v, 0);
    end
  endtask

  task automatic t_regmap();
    logic [31:0] v;
    setup(32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
    rd(12'h460, v); chk("R2 hdr0", v, 32'h11111111);
    rd(12'h464, v); chk("R2 hdr1", v, 32'h22222222);
    rd(12'h468, v); chk("R2 hdr2", v, 32'h33333333);
    rd(12'h470, v); chk("R2 wdata", v, 32'h44444444);
    rd(12'h474, v); chk("R2 unmapped", v, 0);
  endtask

  task automatic t_read_ok();
    logic [31:0] v, d0, d1, d2;
    d0 = mk_dw0(3'd0); d1 = mk_be(6, 2); d2 = mk_dw2(8'h03, 5'd2, 3'd1, 12'h006);
    setup(d0, d1, d2, 32'h0);
    wr(12'h488, 1);
    chk("R3 tx_valid", tx_valid, 1);
    chk("R3 tx_hdr", tx_hdr, {d2, d1, d0});
    rd(12'h488, v); chk("R3 busy bit", v, 32'h1);
    cpl_valid = 1; cpl_status = 3'd0; cpl_data = 32'hDEAD0000;
    @(negedge clk); cpl_valid = 0;
    rd(12'h488, v); chk("R6 early cpl ignored", v, 32'h1);
    repeat (2) @(negedge clk);
    chk("R5 hdr held", tx_hdr, {d2, d1, d0});
    chk("R5 valid held", tx_valid, 1);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    chk("R5 valid drops after accept", tx_valid, 0);
    cpl_valid = 1; cpl_status = 3'd0; cpl_data = 32'hABCD1234;
    @(negedge clk); cpl_valid = 0;
    rd(12'h488, v); chk("R6 done ok", v, 32'h0);
    rd(12'h48C, v); chk("R7 read payload", v, 32'hABCD1234);
    chk("R7 extract", (v >> 16) & 32'hFFFF, 32'hABCD);
  endtask

  task automatic t_write_ok();
    logic [31:0] v, d1;
    d1 = mk_be(13, 1);
    setup(mk_dw0(3'd2), d1, mk_dw2(8'h01, 5'd0, 3'd0, 12'h00D), 32'h5A << 8);
    chk("R4 be mask", d1, 32'h2);
    wr(12'h488, 1);
    chk("R3 tx_data", tx_data, 32'h00005A00);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    cpl_valid = 1; cpl_status = 3'd0; cpl_data = 32'h77777777;
    @(negedge clk); cpl_valid = 0;
    rd(12'h488, v); chk("R6 write done", v, 0);
    rd(12'h48C, v); chk("R7 rdata unchanged by write", v, 32'hABCD1234);
  endtask

  task automatic t_read_err();
    logic [31:0] v;
    setup(mk_dw0(3'd0), 32'hF, mk_dw2(8'h02, 5'd1, 3'd0, 12'h000), 0);
    wr(12'h488, 1);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    cpl_valid = 1; cpl_status = 3'b010; cpl_data = 32'h12345678;
    @(negedge clk); cpl_valid = 0;
    rd(12'h488, v); chk("R11 status field", v, 32'h2 << 5);
    rd(12'h48C, v); chk("R8 failed read all ones", v, 32'hFFFFFFFF);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v, d0;
    d0 = mk_dw0(3'd0);
    setup(d0, 32'h1, 32'h0, 32'h0);
    wr(12'h488, 1);
    rd(12'h488, v); chk("R11 status cleared at launch", v, 32'h1);
    wr(12'h460, 32'hCAFECAFE); wr(12'h470, 32'hBEEF);
    rd(12'h460, v); chk("R9 hdr write ignored", v, d0);
    rd(12'h470, v); chk("R9 wdata write ignored", v, 0);
    tx_ready = 1; @(negedge clk); tx_ready = 0;
    wr(12'h488, 1);
    chk("R9 relaunch ignored", tx_valid, 0);
    cpl_valid = 1; cpl_status = 0; cpl_data = 32'h0BADF00D;
    @(negedge clk); cpl_valid = 0;
    rd(12'h488, v); chk("R9 single completion ends it", v, 0);
    chk("R9 no resend", tx_valid, 0);
  endtask

  task automatic t_bad_hdr();
    logic [31:0] v;
    setup({3'd0, 5'd5, 14'd0, 10'd1}, 32'h1, 0, 0);
    wr(12'h488, 1);
    chk("R4 bad type not sent", tx_valid, 0);
    rd(12'h488, v); chk("R4 bad type status", v, 32'h4 << 5);
    rd(12'h48C, v); chk("R4 rdata ones", v, 32'hFFFFFFFF);
    setup(mk_dw0(3'd0), 32'h0, 0, 0);
    wr(12'h488, 1);
    rd(12'h488, v); chk("R4 empty byte enables", v, 32'h4 << 5);
    setup(mk_dw0(3'd0), 32'h10, 0, 0);
    wr(12'h488, 1);
    rd(12'h488, v); chk("R4 high dw1 bits", v, 32'h4 << 5);
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    setup(mk_dw0(3'd0), 32'h3, 0, 0);
    wr(32'h0, 0);
    wr(12'h48C, 0);
    wr(12'h488, 1);
    repeat (TMO - 1) @(negedge clk);
    rd(12'h488, v); chk("R10 busy before limit", v, 32'h1);
    chk("R10 valid before limit", tx_valid, 1);
    @(negedge clk);
    rd(12'h488, v); chk("R10 timeout status", v, 32'h1 << 5);
    chk("R10 valid dropped", tx_valid, 0);
    rd(12'h48C, v); chk("R8 timeout read ones", v, 32'hFFFFFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_read_ok();
    t_write_ok();
    t_read_err();
    t_busy_ignore();
    t_bad_hdr();
    t_timeout();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule